// File: doc/BRIEF.md
# FIFO Read-Side Output Register

This block is the optional pipeline stage on the read side of a block-RAM FIFO. On each read-clock edge it registers three lanes: 32 bits of data, 4 parity bits and 4 extra-parity bits. A clock enable controls when it registers. A synchronous set/reset input loads the register from a 40-bit preset word instead. How the preset word is placed depends on the configured read width. The low bits fill the data lane first. The next bits fill the parity lane. The bits after those fill the extra-parity lane. Every lane bit that the chosen width does not use is loaded with zero.

Two parameters set how reset behaves. One picks the active level of the reset pin. The other picks which input wins. In reset-wins mode, an active reset always loads the preset word. In enable-gated mode, the preset word is loaded only on edges where the clock enable is also high. If the read-width parameter is not a supported value, elaboration stops with an error.

Top module: `fifo_out_reg`

## Requirements
- R1: Parameter `RST_LEVEL` sets the active level of `rst_pin`: 1 means active-high, 0 means active-low (default 1).
- R2: With `RST_WINS`=1, an active reset loads the mapped preset word on the next edge, whatever the level of `ce`.
- R3: With `RST_WINS`=0, the preset is loaded only when reset and `ce` are both active. An active reset with `ce` low leaves the outputs unchanged.
- R4: For widths 40, 36 and 32, `dout` takes `set_val[31:0]`. At 40 and 36, `doutp` takes `set_val[35:32]`. At 40 only, `doutpx` takes `set_val[39:36]`.
- R5: For widths 20, 18 and 16, `dout[15:0]` takes `set_val[15:0]`. At 20 and 18, `doutp[1:0]` takes `set_val[17:16]`. At 20 only, `doutpx[1:0]` takes `set_val[19:18]`.
- R6: For widths 10, 9 and 8, `dout[7:0]` takes `set_val[7:0]`. At 10 and 9, `doutp[0]` takes `set_val[8]`. At 10 only, `doutpx[0]` takes `set_val[9]`.
- R7: At width 5, `dout[3:0]` takes `set_val[3:0]` and `doutp[0]` takes `set_val[4]`. At widths 4, 2 and 1, only `dout` bits below the width are loaded, from the same positions of `set_val`.
- R8: On a preset load, every output bit that the width does not use becomes 0.
- R9: With reset inactive and `ce` high, the outputs take `din`, `dinp` and `dinpx` unchanged on the next edge.
- R10: With reset inactive and `ce` low, the outputs hold their value, whatever `din`, `dinp`, `dinpx` and `set_val` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_pin | input | 1 | Synchronous set/reset, active level from `RST_LEVEL` |
| ce | input | 1 | Register clock enable |
| din | input | 32 | Data lane from the memory |
| dinp | input | 4 | Parity lane from the memory |
| dinpx | input | 4 | Extra-parity lane from the memory |
| set_val | input | 40 | Preset word |
| dout | output | 32 | Registered data lane |
| doutp | output | 4 | Registered parity lane |
| doutpx | output | 4 | Registered extra-parity lane |

## Verification
Every result, whether a preset load, a capture or a hold, appears on the outputs exactly one rising edge after the inputs that caused it. The bench changes inputs on falling edges and checks the outputs on the next falling edge, half a period after the edge that updated them. Thirteen instances run side by side, one for each legal width, and they cycle through both reset levels and both priority modes. Each instance is compared with its own reference model after every step.

// File: rtl/fifo_oreg_pkg.sv
package fifo_oreg_pkg;

    localparam int DATA_W = 32;
    localparam int PAR_W  = 4;
    localparam int XPAR_W = 4;
    localparam int SET_W  = DATA_W + PAR_W + XPAR_W;

    typedef struct packed {
        logic [XPAR_W-1:0] xpar;
        logic [PAR_W-1:0]  par;
        logic [DATA_W-1:0] data;
    } lanes_t;

    // data-lane bits used at a given read width
    function automatic int data_bits(input int w);
        case (w)
            40, 36, 32: return 32;
            20, 18, 16: return 16;
            10, 9, 8:   return 8;
            5, 4:       return 4;
            2:          return 2;
            1:          return 1;
            default:    return 0;
        endcase
    endfunction

    // parity-lane bits used at a given read width
    function automatic int par_bits(input int w);
        case (w)
            40, 36:   return 4;
            20, 18:   return 2;
            10, 9, 5: return 1;
            default:  return 0;
        endcase
    endfunction

    // extra-parity-lane bits used at a given read width
    function automatic int xpar_bits(input int w);
        case (w)
            40:      return 4;
            20:      return 2;
            10:      return 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit width_ok(input int w);
        return data_bits(w) != 0;
    endfunction

endpackage

// File: rtl/oreg_set_map.sv
module oreg_set_map
    import fifo_oreg_pkg::*;
#(
    parameter int RD_WIDTH = 40
) (
    input  logic [SET_W-1:0] set_val,
    output lanes_t           mapped
);
    localparam int DW    = data_bits(RD_WIDTH);
    localparam int PW    = par_bits(RD_WIDTH);
    localparam int XW    = xpar_bits(RD_WIDTH);
    localparam int P_OFS = DW;
    localparam int X_OFS = DW + PW;

    logic [DATA_W-1:0] d_bits;
    logic [PAR_W-1:0]  p_bits;
    logic [XPAR_W-1:0] x_bits;

    for (genvar i = 0; i < DATA_W; i++) begin : g_data
        if (i < DW) begin : g_live
            assign d_bits[i] = set_val[i];
        end else begin : g_zero
            assign d_bits[i] = 1'b0;
        end
    end

    for (genvar i = 0; i < PAR_W; i++) begin : g_par
        if (i < PW) begin : g_live
            assign p_bits[i] = set_val[P_OFS + i];
        end else begin : g_zero
            assign p_bits[i] = 1'b0;
        end
    end

    for (genvar i = 0; i < XPAR_W; i++) begin : g_xpar
        if (i < XW) begin : g_live
            assign x_bits[i] = set_val[X_OFS + i];
        end else begin : g_zero
            assign x_bits[i] = 1'b0;
        end
    end

    assign mapped = '{xpar: x_bits, par: p_bits, data: d_bits};

endmodule

// File: rtl/oreg_ctrl.sv
module oreg_ctrl #(
    parameter bit RST_LEVEL = 1'b1,
    parameter bit RST_WINS  = 1'b1
) (
    input  logic rst_pin,
    input  logic ce,
    output logic load,
    output logic capture
);
    logic rst_act;

    // R1: reset active when the pin matches the configured level
    assign rst_act = (rst_pin == RST_LEVEL);

    if (RST_WINS) begin : g_rst_wins
        assign load = rst_act;                 // R2
    end else begin : g_ce_gated
        assign load = rst_act & ce;            // R3
    end

    assign capture = ~rst_act & ce;            // R9

endmodule

// File: rtl/fifo_out_reg.sv
module fifo_out_reg
    import fifo_oreg_pkg::*;
#(
    parameter int RD_WIDTH  = 40,
    parameter bit RST_LEVEL = 1'b1,
    parameter bit RST_WINS  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_pin,
    input  logic              ce,
    input  logic [DATA_W-1:0] din,
    input  logic [PAR_W-1:0]  dinp,
    input  logic [XPAR_W-1:0] dinpx,
    input  logic [SET_W-1:0]  set_val,
    output logic [DATA_W-1:0] dout,
    output logic [PAR_W-1:0]  doutp,
    output logic [XPAR_W-1:0] doutpx
);
    if (!width_ok(RD_WIDTH)) begin : g_bad_width
        $error("fifo_out_reg: unsupported RD_WIDTH %0d", RD_WIDTH);
    end

    lanes_t preset;
    logic   load;
    logic   capture;
    lanes_t lanes_d;
    lanes_t lanes_q;

    oreg_set_map #(.RD_WIDTH(RD_WIDTH)) u_map (
        .set_val (set_val),
        .mapped  (preset)
    );

    oreg_ctrl #(.RST_LEVEL(RST_LEVEL), .RST_WINS(RST_WINS)) u_ctrl (
        .rst_pin (rst_pin),
        .ce      (ce),
        .load    (load),
        .capture (capture)
    );

    always_comb begin
        lanes_d = lanes_q;                                   // R10 hold
        if (load) begin
            lanes_d = preset;                                // R2..R8
        end else if (capture) begin
            lanes_d = '{xpar: dinpx, par: dinp, data: din};  // R9
        end
    end

    always_ff @(posedge clk) begin
        lanes_q <= lanes_d;
    end

    assign dout   = lanes_q.data;
    assign doutp  = lanes_q.par;
    assign doutpx = lanes_q.xpar;

endmodule

// File: rtl/fifo_out_reg_chk.sv
module fifo_out_reg_chk
    import fifo_oreg_pkg::*;
#(
    parameter int RD_WIDTH  = 40,
    parameter bit RST_LEVEL = 1'b1,
    parameter bit RST_WINS  = 1'b1
) (
    input logic              clk,
    input logic              rst_pin,
    input logic              ce,
    input logic [DATA_W-1:0] din,
    input logic [PAR_W-1:0]  dinp,
    input logic [XPAR_W-1:0] dinpx,
    input logic [SET_W-1:0]  set_val,
    input logic [DATA_W-1:0] dout,
    input logic [PAR_W-1:0]  doutp,
    input logic [XPAR_W-1:0] doutpx
);
    localparam int DW = data_bits(RD_WIDTH);
    localparam int PW = par_bits(RD_WIDTH);
    localparam int XW = xpar_bits(RD_WIDTH);
    localparam logic [DATA_W-1:0] DMASK = DATA_W'((64'd1 << DW) - 64'd1);
    localparam logic [SET_W-1:0] LIVE =
        {XPAR_W'((64'd1 << XW) - 64'd1), PAR_W'((64'd1 << PW) - 64'd1), DMASK};

    logic primed_q = 1'b0;
    always_ff @(posedge clk) primed_q <= 1'b1;

    logic             rst_act;   // R1
    logic [SET_W-1:0] q_all;
    assign rst_act = (rst_pin == RST_LEVEL);
    assign q_all   = {doutpx, doutp, dout};

    assert_reset_wins_R2: assert property (@(posedge clk) disable iff (!primed_q)
        (RST_WINS && rst_act) |=> ((dout & DMASK) == ($past(set_val[DATA_W-1:0]) & DMASK)));

    assert_enable_gate_R3: assert property (@(posedge clk) disable iff (!primed_q)
        (!RST_WINS && rst_act && !ce) |=> $stable(q_all));

    assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!primed_q)
        (rst_act && (RST_WINS || ce)) |=> ((q_all & ~LIVE) == '0));

    assert_capture_R9: assert property (@(posedge clk) disable iff (!primed_q)
        (!rst_act && ce) |=> (q_all == $past({dinpx, dinp, din})));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!primed_q)
        (!rst_act && !ce) |=> $stable(q_all));

endmodule

bind fifo_out_reg fifo_out_reg_chk #(
    .RD_WIDTH(RD_WIDTH), .RST_LEVEL(RST_LEVEL), .RST_WINS(RST_WINS)
) u_chk (
    .clk(clk), .rst_pin(rst_pin), .ce(ce), .din(din), .dinp(dinp), .dinpx(dinpx),
    .set_val(set_val), .dout(dout), .doutp(doutp), .doutpx(doutpx)
);

// File: tb/fifo_out_reg_test.sv
`timescale 1ns/1ps
module fifo_out_reg_test;

    localparam int N = 13;
    localparam int WIDTHS [N] = '{40, 36, 32, 20, 18, 16, 10, 9, 8, 5, 4, 2, 1};

    typedef struct packed {
        logic        rst;   // logical reset request, mapped per instance polarity
        logic        ce;
        logic [31:0] d;
        logic [3:0]  p;
        logic [3:0]  x;
        logic [39:0] s;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 32'h0000_0000, 4'h0, 4'h0, 40'hA5_5A_C3_96_E1},
        '{1'b0, 1'b1, 32'hDEAD_BEEF, 4'h9, 4'h6, 40'h00_0000_0000},
        '{1'b0, 1'b0, 32'h1234_5678, 4'h3, 4'hC, 40'hFF_FFFF_FFFF},
        '{1'b1, 1'b0, 32'hCAFE_F00D, 4'h5, 4'hA, 40'h3C_7E_81_24_DB},
        '{1'b1, 1'b1, 32'h0F0F_0F0F, 4'h1, 4'h2, 40'h96_E1_4B_D2_2D},
        '{1'b0, 1'b1, 32'h8000_0001, 4'h8, 4'h1, 40'h11_2233_4455},
        '{1'b1, 1'b0, 32'h5555_AAAA, 4'hF, 4'hF, 40'h6B_1D_F0_0F_A7},
        '{1'b0, 1'b0, 32'hFFFF_0000, 4'h7, 4'h7, 40'h00_0000_0001},
        '{1'b1, 1'b1, 32'h0000_0000, 4'h0, 4'h0, 40'hFF_FFFF_FFFF},
        '{1'b0, 1'b1, 32'hFFFF_FFFF, 4'hF, 4'hF, 40'h00_0000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_log;
    logic        ce;
    logic [31:0] din;
    logic [3:0]  dinp;
    logic [3:0]  dinpx;
    logic [39:0] set_val;
    logic [39:0] q_a [N];

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar g = 0; g < N; g++) begin : g_dut
        localparam bit POL  = 1'(g % 2);
        localparam bit WINS = 1'(((g / 2) % 2) == 0);
        logic        pin;
        logic [31:0] d_o;
        logic [3:0]  p_o;
        logic [3:0]  x_o;
        assign pin = rst_log ? POL : ~POL;
        fifo_out_reg #(.RD_WIDTH(WIDTHS[g]), .RST_LEVEL(POL), .RST_WINS(WINS)) uut (
            .clk(clk), .rst_pin(pin), .ce(ce), .din(din), .dinp(dinp), .dinpx(dinpx),
            .set_val(set_val), .dout(d_o), .doutp(p_o), .doutpx(x_o)
        );
        assign q_a[g] = {x_o, p_o, d_o};
    end

    function automatic logic [39:0] ref_map(input int w, input logic [39:0] s);
        int dw, pw, xw;
        logic [63:0] sv, dmk, pmk, xmk;
        dw = (w >= 32) ? 32 : (w >= 16) ? 16 : (w >= 8) ? 8 : (w >= 4) ? 4 : w;
        pw = (w == 40 || w == 36) ? 4 : (w == 20 || w == 18) ? 2 :
             (w == 10 || w == 9 || w == 5) ? 1 : 0;
        xw = (w == 40) ? 4 : (w == 20) ? 2 : (w == 10) ? 1 : 0;
        sv  = {24'd0, s};
        dmk = (64'd1 << dw) - 64'd1;
        pmk = (64'd1 << pw) - 64'd1;
        xmk = (64'd1 << xw) - 64'd1;
        return {4'((sv >> (dw + pw)) & xmk), 4'((sv >> dw) & pmk), 32'(sv & dmk)};
    endfunction

    function automatic string width_tag(input int w);
        if (w >= 32) return "R4";
        if (w >= 16) return "R5";
        if (w >= 8)  return "R6";
        return "R7";
    endfunction

    logic [39:0] model [N];
    string       tags  [N];

    task automatic apply(input vec_t v);
        rst_log = v.rst; ce = v.ce; din = v.d; dinp = v.p; dinpx = v.x; set_val = v.s;
        for (int g = 0; g < N; g++) begin
            bit pol  = 1'(g % 2);
            bit wins = ((g / 2) % 2) == 0;
            if (v.rst && (wins || v.ce)) begin
                model[g] = ref_map(WIDTHS[g], v.s);
                tags[g]  = $sformatf("%s%s R8 %s", pol ? "" : "R1 ",
                                     wins ? "R2" : "R3", width_tag(WIDTHS[g]));
            end else if (!v.rst && v.ce) begin
                model[g] = {v.x, v.p, v.d};
                tags[g]  = "R9";
            end else begin
                tags[g]  = v.rst ? "R3" : "R10";
            end
        end
    endtask

    task automatic check_all();
        for (int g = 0; g < N; g++) begin
            checks++;
            if (q_a[g] !== model[g]) begin
                failures++;
                $display("FAIL [%s] width=%0d actual=%h expected=%h",
                         tags[g], WIDTHS[g], q_a[g], model[g]);
            end
        end
    endtask

    task automatic step(input vec_t v);
        apply(v);
        @(negedge clk);
        check_all();
    endtask

    initial begin
        vec_t v;
        step(VECS[0]);   // reset state: all instances loaded on the first edge
        for (int i = 1; i < NV; i++) step(VECS[i]);

        // directed R10: several idle cycles with moving data and preset
        for (int i = 0; i < 3; i++) begin
            v = '{1'b0, 1'b0, 32'h1111_1111 * 32'(i + 3), 4'(i), 4'(i + 7), 40'hF0_F0F0_F0F0};
            step(v);
        end
        // directed R2 vs R3: reset held two cycles with clock enable low
        step('{1'b1, 1'b0, 32'h0, 4'h0, 4'h0, 40'h5A_A5_5A_A5_5A});
        step('{1'b1, 1'b0, 32'h0, 4'h0, 4'h0, 40'hC3_3C_C3_3C_C3});
        // directed R8: all-ones preset with enable high, then release
        step('{1'b1, 1'b1, 32'h0, 4'h0, 4'h0, 40'hFF_FFFF_FFFF});
        step('{1'b0, 1'b0, 32'hABCD_EF01, 4'hE, 4'hD, 40'h0});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL [watchdog] actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule